// File: doc/BRIEF.md
# Five-Function Integer ALU with Zero Flag

This block is the arithmetic and logic stage of a small load/store processor. It is purely combinational. Two 32-bit operands and a 3-bit operation code go in. A 32-bit result and a flag that marks an all-zero result come out. The operations are add, subtract, bitwise AND, bitwise OR, and a signed compare that yields 1 or 0.

Branch-on-equal logic selects subtract and reads the zero flag to decide whether the operands match. Load and store address generation use the add operation. Operand muxing, immediate extension, overflow traps and shifts belong to the surrounding datapath.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 gives the sum of the two operands, wrapped modulo 2^32, with no carry or overflow output.
- R2: Code 3'b001 gives the first operand minus the second, wrapped modulo 2^32.
- R3: Code 3'b010 gives the bitwise AND of the operands.
- R4: Code 3'b110 gives the bitwise OR of the operands.
- R5: Code 3'b111 gives 1 in bit 0 when the first operand is less than the second as signed two's-complement numbers, and 0 otherwise. Bits 31..1 are always 0.
- R6: The signed compare under code 3'b111 is correct when the internal difference overflows, for example 0x80000000 against 0x00000001 and 0x7FFFFFFF against 0xFFFFFFFF.
- R7: The zero flag is 1 exactly when all 32 result bits are 0, whatever the code.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give a result of 0, so the zero flag is 1 for any operands.
- R9: Under code 3'b001 the zero flag is 1 if and only if the two operands are equal, which is the condition a branch-on-equal tests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand (minuend, left side of compare) |
| opB | input | 32 | Second operand (subtrahend, right side of compare) |
| aluOp | input | 3 | Operation code |
| result | output | 32 | Operation result |
| isZero | output | 1 | High when result is all zeros |

## Verification
The bound checker evaluates every input change and tests several relations at the ports:
- the result of each coded operation against an arithmetic expression of the operands,
- the zero-result behaviour of the unused codes,
- that the zero flag agrees with the result,
- that under subtract the zero flag means the operands are equal.

Only the bench's scenarios show that the overflow-prone compare pairs were actually applied and produce the right answer. The bench scenarios also cover patterned operands such as alternating bits, the all-ones operand and wrap-around sums, and they sweep all eight codes over random operands.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b110,
    OP_SLT = 3'b111
  } aluCode_e;

  // One strobe per datapath function; at most one is high.
  typedef struct packed {
    logic addEn;
    logic subEn;
    logic andEn;
    logic orEn;
    logic sltEn;
  } aluStrobe_t;

endpackage

// File: rtl/alu_core_ctrl.sv
module alu_core_ctrl
  import alu_core_pkg::*;
(
  input  logic [OP_W-1:0] aluOp,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    case (aluOp)
      OP_ADD:  strobe.addEn = 1'b1;
      OP_SUB:  strobe.subEn = 1'b1;
      OP_AND:  strobe.andEn = 1'b1;
      OP_OR:   strobe.orEn  = 1'b1;
      OP_SLT:  strobe.sltEn = 1'b1;
      default: strobe = '0;   // spare codes: no function selected
    endcase
  end

endmodule

// File: rtl/alu_core_dp.sv
module alu_core_dp
  import alu_core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result
);

  localparam int MSB = WIDTH - 1;

  logic             invertB;
  logic [WIDTH-1:0] bOperand;
  logic [WIDTH-1:0] sumOut;
  logic             signedOvf;
  logic             lessThan;
  logic [WIDTH-1:0] sltWord;
  logic             arithSel;

  // A single adder serves add, subtract and compare.
  assign invertB  = strobe.subEn | strobe.sltEn;
  assign bOperand = invertB ? ~opB : opB;
  assign sumOut   = opA + bOperand + {{(WIDTH-1){1'b0}}, invertB};

  // The sign of the difference is wrong exactly when it overflowed.
  assign signedOvf = (opA[MSB] == bOperand[MSB]) && (sumOut[MSB] != opA[MSB]);
  assign lessThan  = sumOut[MSB] ^ signedOvf;
  assign sltWord   = {{(WIDTH-1){1'b0}}, lessThan};

  assign arithSel = strobe.addEn | strobe.subEn;

  // AND-OR result select; all strobes low yields zero.
  assign result = ({WIDTH{arithSel}}     & sumOut)
                | ({WIDTH{strobe.andEn}} & (opA & opB))
                | ({WIDTH{strobe.orEn}}  & (opA | opB))
                | ({WIDTH{strobe.sltEn}} & sltWord);

endmodule

// File: rtl/alu_core_zero.sv
module alu_core_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             isZero
);

  assign isZero = ~|value;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  aluOp,
  output logic [WIDTH-1:0] result,
  output logic             isZero
);

  aluStrobe_t strobe;

  alu_core_ctrl u_ctrl (
    .aluOp  (aluOp),
    .strobe (strobe)
  );

  alu_core_dp #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

  alu_core_zero #(.WIDTH(WIDTH)) u_zero (
    .value  (result),
    .isZero (isZero)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       aluOp,
  input logic [WIDTH-1:0] result,
  input logic             isZero
);

  logic             sLess;
  logic [WIDTH-1:0] zeroW;

  assign sLess = $signed(opA) < $signed(opB);
  assign zeroW = '0;

  always_comb begin
    if (aluOp == 3'b000)
      p_add_wraps_r1: assert (result == WIDTH'(opA + opB));
    if (aluOp == 3'b001)
      p_sub_wraps_r2: assert (result == WIDTH'(opA - opB));
    if (aluOp == 3'b010)
      p_and_bits_r3: assert (result == (opA & opB));
    if (aluOp == 3'b110)
      p_or_bits_r4: assert (result == (opA | opB));
    // R6 is covered by the same signed relation
    if (aluOp == 3'b111)
      p_slt_signed_r5: assert (result == {{(WIDTH-1){1'b0}}, sLess});
    if (aluOp == 3'b011 || aluOp == 3'b100 || aluOp == 3'b101)
      p_spare_zero_r8: assert (result == zeroW && isZero);
    p_zero_flag_r7: assert (isZero == (result == zeroW));
    if (aluOp == 3'b001)
      p_beq_equal_r9: assert (isZero == (opA == opB));
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .opA    (opA),
  .opB    (opB),
  .aluOp  (aluOp),
  .result (result),
  .isZero (isZero)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   aluOp = 3'b000;
  logic [W-1:0] result;
  logic         isZero;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  alu_core #(.WIDTH(W)) u0 (
    .opA    (opA),
    .opB    (opB),
    .aluOp  (aluOp),
    .result (result),
    .isZero (isZero)
  );

  function automatic logic [W-1:0] refResult(input logic [2:0] op,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    case (op)
      3'b000:  return a + b;
      3'b001:  return a - b;
      3'b010:  return a & b;
      3'b110:  return a | b;
      3'b111:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               tag, aluOp, opA, opB, got, exp);
    end
  endtask

  // Drive away from the clock edge, sample after settling.
  task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    aluOp = op; opA = a; opB = b;
    #2;
  endtask

  task automatic runOne(input string tag, input logic [2:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] e;
    apply(op, a, b);
    e = refResult(op, a, b);
    check(tag, result, e);
    check("R7", {31'b0, isZero}, {31'b0, e == '0});
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    check("R1 reset", result, '0);
    check("R7 reset", {31'b0, isZero}, 32'd1);
  endtask

  task automatic t_add;
    runOne("R1", 3'b000, 32'h0000_0005, 32'h0000_0007);
    runOne("R1", 3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
    runOne("R1", 3'b000, 32'h8000_0000, 32'h8000_0000);
    runOne("R1", 3'b000, 32'h1234_5678, 32'h0FED_CBA9);
  endtask

  task automatic t_sub;
    runOne("R2", 3'b001, 32'h0000_0010, 32'h0000_0003);
    runOne("R2", 3'b001, 32'h0000_0000, 32'h0000_0001);
    runOne("R2", 3'b001, 32'h8000_0000, 32'h0000_0001);
  endtask

  task automatic t_logic;
    runOne("R3", 3'b010, 32'hAAAA_AAAA, 32'h5555_5555);
    runOne("R3", 3'b010, 32'hF0F0_FFFF, 32'hFF00_00F0);
    runOne("R4", 3'b110, 32'hAAAA_AAAA, 32'h5555_5555);
    runOne("R4", 3'b110, 32'h0000_0000, 32'h0000_0000);
    runOne("R4", 3'b110, 32'h1200_0034, 32'h0056_7800);
  endtask

  task automatic t_slt;
    runOne("R5", 3'b111, 32'd3, 32'd9);
    runOne("R5", 3'b111, 32'd9, 32'd3);
    runOne("R5", 3'b111, 32'd7, 32'd7);
    runOne("R5", 3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
    apply(3'b111, 32'h8000_0000, 32'h0000_0001);
    check("R6 min<1", result, 32'd1);
    apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    check("R6 max<-1", result, 32'd0);
    apply(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R6 min<max", result, 32'd1);
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R6 max<min", result, 32'd0);
  endtask

  task automatic t_spare;
    for (int c = 3; c <= 5; c++) begin
      apply(3'(c), 32'hDEAD_BEEF, 32'hFFFF_FFFF);
      check("R8 result", result, '0);
      check("R8 flag", {31'b0, isZero}, 32'd1);
    end
  endtask

  task automatic t_beq;
    apply(3'b001, 32'hCAFE_F00D, 32'hCAFE_F00D);
    check("R9 equal", {31'b0, isZero}, 32'd1);
    apply(3'b001, 32'hCAFE_F00D, 32'hCAFE_F00C);
    check("R9 differ", {31'b0, isZero}, 32'd0);
    apply(3'b001, 32'h0000_0000, 32'h8000_0000);
    check("R9 differ msb", {31'b0, isZero}, 32'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 7 == 0) ? a : $urandom;
      runOne("R1..op sweep", 3'(i % 8), a, b);
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_slt();
    t_spare();
    t_beq();
    t_random();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule